// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host that sees only a 64-bit memory-mapped window reach a 32-bit register bus owned by an embedded processor. The host writes a single command word holding an opcode, a 13-bit internal register address and 32 bits of write data. The bridge turns that into one request on the internal bus and waits for the acknowledge. It then raises a completion flag in a status word, which also holds the returned read data, and the host polls that word.

A third, read-only word describes the serial-peripheral controller behind the bridge: bit order, word width, number of chip selects, clock polarity and phase, and a 16-bit peripheral identifier. Its fields are fixed by module parameters. The bridge handles one internal access at a time. A command that arrives while one is outstanding is dropped, and the running access completes normally.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the status word (host offset 0x18) reads zero: the completion flag (bit 32) is clear and the data field (bits 31:0) is zero.
- R2: Host offset 0x08 returns the description word: bit 1 is shift order (1 = LSB first), bits 7:2 are the word width, bits 13:8 are the chip-select count, bit 14 is clock polarity, bit 15 is clock phase, bits 47:32 are the peripheral ID, and all other bits are zero.
- R3: A host write to offset 0x10 with opcode bits 63:62 equal to 1 (read) or 2 (write), made while the bridge is idle, produces exactly one single-cycle `ib_req` in the next cycle. That request carries the address from bits 44:32, the data from bits 31:0, and `ib_we` high only for opcode 2.
- R4: An accepted read or write command clears the completion flag in the cycle after the command write.
- R5: An `ib_ack` while an access is outstanding sets the completion flag in the next cycle. For a read, the same edge copies `ib_rdata` into status bits 31:0.
- R6: Completion of a write access leaves status bits 31:0 unchanged.
- R7: Opcode 0 (no operation) and opcode 3 (reserved) issue no request and leave the status word unchanged.
- R8: A command written while an access is outstanding is ignored. This includes a command in the cycle the acknowledge arrives. The outstanding access completes with its own data.
- R9: An `ib_ack` while no access is outstanding is ignored: the status word is unchanged and no request is issued.
- R10: Reads of offset 0x10 and of every offset other than 0x08 and 0x18 return zero.
- R11: Host writes to offsets 0x08 and 0x18 have no effect on the words read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_wen | input | 1 | Host write strobe, one cycle per write |
| hst_waddr | input | HOST_AW | Host write byte offset |
| hst_wdata | input | 64 | Host write data |
| hst_raddr | input | HOST_AW | Host read byte offset |
| hst_rdata | output | 64 | Host read data for `hst_raddr` |
| ib_req | output | 1 | Internal bus request pulse |
| ib_addr | output | IB_AW | Internal register address |
| ib_we | output | 1 | Internal access is a write |
| ib_wdata | output | IB_DW | Internal write data |
| ib_ack | input | 1 | Internal access complete |
| ib_rdata | input | IB_DW | Internal read data, valid with `ib_ack` |

## Verification
The hardest case to reach from the ports is a second command that lands in the same cycle as the acknowledge of the first. A responder with zero latency reaches it: the bench issues two command writes back to back, so the second one meets the acknowledge edge. The bench also holds accesses open with long responder latencies while it fires further commands. It injects a stray acknowledge while the bridge is idle, and it drives random read data on every cycle so that any capture outside a read acknowledge becomes visible.

// File: rtl/irb_pkg.sv
package irb_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } irb_op_e;

  // host window byte offsets
  localparam int unsigned OFS_DESC = 32'h08;
  localparam int unsigned OFS_CMD  = 32'h10;
  localparam int unsigned OFS_STAT = 32'h18;

  localparam int unsigned HOST_DW = 64;

  // command word layout
  localparam int unsigned CMD_OP_LO   = 62;
  localparam int unsigned CMD_ADDR_LO = 32;
  localparam int unsigned CMD_DATA_LO = 0;

  // status word layout
  localparam int unsigned STAT_FLAG_BIT = 32;

  // description word layout
  localparam int unsigned DESC_ORDER_BIT = 1;
  localparam int unsigned DESC_WIDTH_LO  = 2;
  localparam int unsigned DESC_CS_LO     = 8;
  localparam int unsigned DESC_POL_BIT   = 14;
  localparam int unsigned DESC_PHA_BIT   = 15;
  localparam int unsigned DESC_ID_LO     = 32;

endpackage

// File: rtl/irb_rst_sync.sv
module irb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/irb_host_decode.sv
module irb_host_decode
  import irb_pkg::*;
#(
  parameter int unsigned HOST_AW = 8
) (
  input  logic               hst_wen,
  input  logic [HOST_AW-1:0] hst_waddr,
  input  logic [HOST_AW-1:0] hst_raddr,
  input  logic [HOST_DW-1:0] desc_word,
  input  logic [HOST_DW-1:0] stat_word,
  output logic               cmd_wr,
  output logic [HOST_DW-1:0] hst_rdata
);

  localparam logic [HOST_AW-1:0] A_DESC = HOST_AW'(OFS_DESC);
  localparam logic [HOST_AW-1:0] A_CMD  = HOST_AW'(OFS_CMD);
  localparam logic [HOST_AW-1:0] A_STAT = HOST_AW'(OFS_STAT);

  assign cmd_wr = hst_wen && (hst_waddr == A_CMD);

  always_comb begin
    if (hst_raddr == A_DESC) begin
      hst_rdata = desc_word;
    end else if (hst_raddr == A_STAT) begin
      hst_rdata = stat_word;
    end else begin
      hst_rdata = '0;
    end
  end

endmodule

// File: rtl/irb_cmd_engine.sv
module irb_cmd_engine
  import irb_pkg::*;
#(
  parameter int unsigned IB_AW = 13,
  parameter int unsigned IB_DW = 32
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             cmd_wr,
  input  logic [1:0]       cmd_op,
  input  logic [IB_AW-1:0] cmd_addr,
  input  logic [IB_DW-1:0] cmd_data,
  input  logic             ib_ack,
  output logic             ib_req,
  output logic [IB_AW-1:0] ib_addr,
  output logic             ib_we,
  output logic [IB_DW-1:0] ib_wdata,
  output logic             busy,
  output logic             rd_pending,
  output logic             launch,
  output logic             done
);

  irb_op_e op;
  logic    busy_q, busy_d;
  logic    req_q, req_d;
  logic    rd_q, rd_d;
  logic    we_q, we_d;
  logic [IB_AW-1:0] addr_q, addr_d;
  logic [IB_DW-1:0] wdata_q, wdata_d;

  assign op     = irb_op_e'(cmd_op);
  assign launch = cmd_wr && !busy_q && ((op == OP_READ) || (op == OP_WRITE));
  assign done   = busy_q && ib_ack;

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    req_d   = launch;
    if (done) begin
      busy_d = 1'b0;
    end
    if (launch) begin
      busy_d  = 1'b1;
      rd_d    = (op == OP_READ);
      we_d    = (op == OP_WRITE);
      addr_d  = cmd_addr;
      wdata_d = cmd_data;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      rd_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      req_q   <= req_d;
      rd_q    <= rd_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign ib_req     = req_q;
  assign ib_addr    = addr_q;
  assign ib_we      = we_q;
  assign ib_wdata   = wdata_q;
  assign busy       = busy_q;
  assign rd_pending = rd_q;

endmodule

// File: rtl/irb_status_capture.sv
module irb_status_capture #(
  parameter int unsigned IB_DW = 32
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             launch,
  input  logic             done,
  input  logic             rd_pending,
  input  logic [IB_DW-1:0] ib_rdata,
  output logic             flag,
  output logic [IB_DW-1:0] data
);

  logic             flag_q, flag_d;
  logic [IB_DW-1:0] data_q, data_d;
  logic             data_en;

  assign data_en = done && rd_pending;

  always_comb begin
    flag_d = flag_q;
    data_d = data_q;
    if (launch) begin
      flag_d = 1'b0;
    end else if (done) begin
      flag_d = 1'b1;
    end
    if (data_en) begin
      data_d = ib_rdata;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      flag_q <= 1'b0;
      data_q <= '0;
    end else begin
      flag_q <= flag_d;
      data_q <= data_d;
    end
  end

  assign flag = flag_q;
  assign data = data_q;

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import irb_pkg::*;
#(
  parameter int unsigned HOST_AW     = 8,
  parameter int unsigned IB_AW       = 13,
  parameter int unsigned IB_DW       = 32,
  parameter int unsigned RST_STAGES  = 2,
  parameter logic        P_LSB_FIRST = 1'b0,
  parameter logic [5:0]  P_WORD_W    = 6'd32,
  parameter logic [5:0]  P_NUM_CS    = 6'd1,
  parameter logic        P_CPOL      = 1'b0,
  parameter logic        P_CPHA      = 1'b0,
  parameter logic [15:0] P_PERIPH_ID = 16'h0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_wen,
  input  logic [HOST_AW-1:0] hst_waddr,
  input  logic [63:0]        hst_wdata,
  input  logic [HOST_AW-1:0] hst_raddr,
  output logic [63:0]        hst_rdata,
  output logic               ib_req,
  output logic [IB_AW-1:0]   ib_addr,
  output logic               ib_we,
  output logic [IB_DW-1:0]   ib_wdata,
  input  logic               ib_ack,
  input  logic [IB_DW-1:0]   ib_rdata
);

  localparam int unsigned STAT_PAD  = HOST_DW - 1 - IB_DW;
  localparam int unsigned CMD_SPARE = CMD_OP_LO - CMD_ADDR_LO - IB_AW;

  localparam logic [HOST_DW-1:0] DESC_WORD =
      (HOST_DW'(P_PERIPH_ID) << DESC_ID_LO)   |
      (HOST_DW'(P_CPHA)      << DESC_PHA_BIT) |
      (HOST_DW'(P_CPOL)      << DESC_POL_BIT) |
      (HOST_DW'(P_NUM_CS)    << DESC_CS_LO)   |
      (HOST_DW'(P_WORD_W)    << DESC_WIDTH_LO)|
      (HOST_DW'(P_LSB_FIRST) << DESC_ORDER_BIT);

  logic               srst_n;
  logic               cmd_wr;
  logic               eng_busy;
  logic               eng_rd;
  logic               eng_launch;
  logic               eng_done;
  logic               stat_valid;
  logic [IB_DW-1:0]   stat_rdata;
  logic [HOST_DW-1:0] stat_word;
  logic               unused_cmd_bits;

  assign unused_cmd_bits = ^hst_wdata[CMD_OP_LO-1 -: CMD_SPARE];
  assign stat_word       = {{STAT_PAD{1'b0}}, stat_valid, stat_rdata};

  irb_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  irb_host_decode #(.HOST_AW(HOST_AW)) dec_i (
    .hst_wen   (hst_wen),
    .hst_waddr (hst_waddr),
    .hst_raddr (hst_raddr),
    .desc_word (DESC_WORD),
    .stat_word (stat_word),
    .cmd_wr    (cmd_wr),
    .hst_rdata (hst_rdata)
  );

  irb_cmd_engine #(.IB_AW(IB_AW), .IB_DW(IB_DW)) eng_i (
    .clk        (clk),
    .srst_n     (srst_n),
    .cmd_wr     (cmd_wr),
    .cmd_op     (hst_wdata[CMD_OP_LO +: 2]),
    .cmd_addr   (hst_wdata[CMD_ADDR_LO +: IB_AW]),
    .cmd_data   (hst_wdata[CMD_DATA_LO +: IB_DW]),
    .ib_ack     (ib_ack),
    .ib_req     (ib_req),
    .ib_addr    (ib_addr),
    .ib_we      (ib_we),
    .ib_wdata   (ib_wdata),
    .busy       (eng_busy),
    .rd_pending (eng_rd),
    .launch     (eng_launch),
    .done       (eng_done)
  );

  irb_status_capture #(.IB_DW(IB_DW)) stat_i (
    .clk        (clk),
    .srst_n     (srst_n),
    .launch     (eng_launch),
    .done       (eng_done),
    .rd_pending (eng_rd),
    .ib_rdata   (ib_rdata),
    .flag       (stat_valid),
    .data       (stat_rdata)
  );

endmodule

// File: rtl/irb_checker.sv
module irb_checker #(
  parameter int unsigned HOST_AW = 8,
  parameter int unsigned IB_DW   = 32
) (
  input logic               clk,
  input logic               srst_n,
  input logic               hst_wen,
  input logic [HOST_AW-1:0] hst_waddr,
  input logic [1:0]         cmd_op,
  input logic               ib_req,
  input logic               ib_ack,
  input logic               busy,
  input logic               rd_pending,
  input logic               stat_valid,
  input logic [IB_DW-1:0]   stat_rdata
);

  logic rw_cmd_seen;
  assign rw_cmd_seen = hst_wen && (hst_waddr == HOST_AW'(32'h10)) &&
                       ((cmd_op == 2'd1) || (cmd_op == 2'd2));

  // R3
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ib_req |=> !ib_req);

  // R3
  req_has_cause_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ib_req |-> $past(rw_cmd_seen));

  // R4
  req_flag_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ib_req |-> !stat_valid);

  // R5
  ack_sets_flag_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(busy && ib_ack) |-> stat_valid);

  // R9
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(stat_valid) |-> $past(busy && ib_ack));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(busy && ib_ack && rd_pending) |-> $stable(stat_rdata));

  // R8
  no_req_busy_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ib_req |-> !$past(busy));

endmodule

bind ind_reg_bridge irb_checker #(.HOST_AW(HOST_AW), .IB_DW(IB_DW)) chk_i (
  .clk        (clk),
  .srst_n     (srst_n),
  .hst_wen    (hst_wen),
  .hst_waddr  (hst_waddr),
  .cmd_op     (hst_wdata[63:62]),
  .ib_req     (ib_req),
  .ib_ack     (ib_ack),
  .busy       (eng_busy),
  .rd_pending (eng_rd),
  .stat_valid (stat_valid),
  .stat_rdata (stat_rdata)
);

// File: tb/ind_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module ind_reg_bridge_tb_top;

  localparam logic [15:0] T_ID   = 16'hBEEF;
  localparam logic [5:0]  T_WW   = 6'd24;
  localparam logic [5:0]  T_CS   = 6'd3;
  localparam logic [63:0] DESC_EXP = 64'h0000_BEEF_0000_4362;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_wen;
  logic [7:0]  hst_waddr;
  logic [63:0] hst_wdata;
  logic [7:0]  hst_raddr;
  logic [63:0] hst_rdata;
  logic        ib_req;
  logic [12:0] ib_addr;
  logic        ib_we;
  logic [31:0] ib_wdata;
  logic        ib_ack;
  logic [31:0] ib_rdata;

  always #2 clk = ~clk;

  ind_reg_bridge #(
    .P_LSB_FIRST(1'b1), .P_WORD_W(T_WW), .P_NUM_CS(T_CS),
    .P_CPOL(1'b1), .P_CPHA(1'b0), .P_PERIPH_ID(T_ID)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wen(hst_wen), .hst_waddr(hst_waddr),
    .hst_wdata(hst_wdata), .hst_raddr(hst_raddr), .hst_rdata(hst_rdata),
    .ib_req(ib_req), .ib_addr(ib_addr), .ib_we(ib_we), .ib_wdata(ib_wdata),
    .ib_ack(ib_ack), .ib_rdata(ib_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int req_count = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] cmd(input logic [1:0] op, input logic [12:0] a,
                                      input logic [31:0] d);
    return {op, 17'h1ABCD, a, d};
  endfunction

  // behavioural reference model
  bit          m_busy, m_valid, m_rd;
  logic [31:0] m_rdata;
  bit          e_req, e_we;
  logic [12:0] e_addr;
  logic [31:0] e_wdata;
  bit          acc, lau;
  logic [1:0]  mop;
  logic [63:0] exp_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_rd = 0; m_rdata = 0; e_req = 0;
    end else begin
      mop = hst_wdata[63:62];
      acc = m_busy && ib_ack;
      lau = !m_busy && hst_wen && (hst_waddr == 8'h10) && (mop == 2'd1 || mop == 2'd2);
      if (acc) begin
        m_busy = 0; m_valid = 1;
        if (m_rd) m_rdata = ib_rdata;
      end
      if (lau) begin
        m_busy = 1; m_valid = 0; m_rd = (mop == 2'd1);
        e_req = 1; e_we = (mop == 2'd2);
        e_addr = hst_wdata[44:32]; e_wdata = hst_wdata[31:0];
      end else begin
        e_req = 0;
      end
    end
    #1;
    if (ib_req) req_count++;
    if (model_on) begin
      chk("R3 request pulse", 64'(ib_req), 64'(e_req));
      if (e_req) begin
        chk("R3 request address", 64'(ib_addr), 64'(e_addr));
        chk("R3 request direction", 64'(ib_we), 64'(e_we));
        chk("R3 request data", 64'(ib_wdata), 64'(e_wdata));
      end
      if (hst_raddr == 8'h08)      exp_rd = DESC_EXP;
      else if (hst_raddr == 8'h18) exp_rd = {31'b0, m_valid, m_rdata};
      else                         exp_rd = 64'h0;
      chk("R5 R10 host read vs model", hst_rdata, exp_rd);
    end
  end

  // internal bus responder
  int          lat = 0;
  int          cnt = 0;
  bit          stray = 0;
  logic [31:0] last_data = 0;

  initial begin
    ib_ack = 0;
    ib_rdata = 0;
    forever begin
      @(negedge clk);
      ib_ack = 0;
      ib_rdata = $urandom;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) ib_ack = 1;
      end
      if (ib_req) begin
        if (lat == 0) ib_ack = 1;
        else cnt = lat;
      end
      if (stray) begin
        ib_ack = 1;
        stray = 0;
      end
      if (ib_ack) last_data = ib_rdata;
    end
  end

  task automatic host_write(input logic [7:0] a, input logic [63:0] d);
    hst_wen = 1; hst_waddr = a; hst_wdata = d;
    @(negedge clk);
    hst_wen = 0;
  endtask

  task automatic read_at(input logic [7:0] a, input string tag, input logic [63:0] exp);
    hst_raddr = a;
    @(negedge clk);
    chk(tag, hst_rdata, exp);
  endtask

  task automatic wait_done(input string tag);
    hst_raddr = 8'h18;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (hst_rdata[32]) break;
    end
    chk(tag, 64'(hst_rdata[32]), 64'd1);
  endtask

  logic [31:0] kept;
  int          rc;

  initial begin
    rst_n = 0; hst_wen = 0; hst_waddr = 0; hst_wdata = 0; hst_raddr = 8'h18;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_on = 1;

    read_at(8'h18, "R1 status after reset", 64'h0);
    read_at(8'h08, "R2 description word", DESC_EXP);

    host_write(8'h08, '1);
    host_write(8'h18, '1);
    read_at(8'h08, "R11 description after write", DESC_EXP);
    read_at(8'h18, "R11 status after write", 64'h0);

    read_at(8'h10, "R10 command offset reads zero", 64'h0);
    read_at(8'h00, "R10 offset 0x00", 64'h0);
    read_at(8'h0C, "R10 offset 0x0C", 64'h0);
    read_at(8'h20, "R10 offset 0x20", 64'h0);

    // read access, latency 3
    lat = 3;
    hst_raddr = 8'h18;
    host_write(8'h10, cmd(2'd1, 13'h1234, 32'hDEADBEEF));
    wait_done("R5 read completion flag");
    chk("R5 read data captured", hst_rdata, {31'b0, 1'b1, last_data});
    kept = last_data;

    // write access, latency 2
    lat = 2;
    host_write(8'h10, cmd(2'd2, 13'h0004, 32'h11223344));
    chk("R4 flag cleared on launch", 64'(hst_rdata[32]), 64'd0);
    wait_done("R5 write completion flag");
    chk("R6 data kept after write", hst_rdata, {31'b0, 1'b1, kept});

    // no-op and reserved opcode
    rc = req_count;
    host_write(8'h10, cmd(2'd0, 13'h0FFF, 32'hCAFEF00D));
    repeat (4) @(negedge clk);
    chk("R7 no-op issues no request", 64'(req_count), 64'(rc));
    chk("R7 no-op status unchanged", hst_rdata, {31'b0, 1'b1, kept});
    host_write(8'h10, cmd(2'd3, 13'h0AAA, 32'h55555555));
    repeat (4) @(negedge clk);
    chk("R7 reserved issues no request", 64'(req_count), 64'(rc));
    chk("R7 reserved status unchanged", hst_rdata, {31'b0, 1'b1, kept});

    // command while busy, long latency
    lat = 6;
    rc = req_count;
    host_write(8'h10, cmd(2'd1, 13'h0100, 32'h0));
    host_write(8'h10, cmd(2'd2, 13'h0200, 32'h99999999));
    repeat (2) @(negedge clk);
    host_write(8'h10, cmd(2'd1, 13'h0300, 32'h0));
    wait_done("R8 busy access completes");
    repeat (3) @(negedge clk);
    chk("R8 one request while busy", 64'(req_count), 64'(rc + 1));
    chk("R8 busy access data", hst_rdata, {31'b0, 1'b1, last_data});
    kept = last_data;

    // command in the acknowledge cycle
    lat = 0;
    rc = req_count;
    host_write(8'h10, cmd(2'd1, 13'h0400, 32'h0));
    host_write(8'h10, cmd(2'd2, 13'h0500, 32'h77777777));
    repeat (4) @(negedge clk);
    chk("R8 command in ack cycle dropped", 64'(req_count), 64'(rc + 1));
    chk("R5 zero-latency read data", hst_rdata, {31'b0, 1'b1, last_data});
    kept = last_data;

    // stray acknowledge while idle
    rc = req_count;
    @(posedge clk);
    stray = 1;
    repeat (3) @(negedge clk);
    chk("R9 stray ack keeps status", hst_rdata, {31'b0, 1'b1, kept});
    chk("R9 stray ack issues no request", 64'(req_count), 64'(rc));

    // normal access after the stray
    lat = 1;
    host_write(8'h10, cmd(2'd1, 13'h1FFF, 32'h0));
    chk("R4 flag cleared on launch", 64'(hst_rdata[32]), 64'd0);
    wait_done("R5 read after stray");
    chk("R5 read data after stray", hst_rdata, {31'b0, 1'b1, last_data});

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule